// File: doc/BRIEF.md
# Paged Write Load Controller

This block is the write front end of a byte-wide, page-organised non-volatile memory. It watches three asynchronous active-low strobes (chip select, output enable, write strobe) together with an address bus and a data bus, all sampled in the system clock domain. A write is taken when chip select and write strobe are both low while output enable is high. The address is taken when that condition begins, and the data is taken when it ends. The low portion of a page address selects the byte slot, and each accepted byte is placed into a page buffer that keeps one mark bit per slot.

The first accepted byte opens a load window and fixes the page. Further bytes may follow in any order, and a slot may be overwritten. When no new write starts within a parameterised number of idle cycles after the last release, the window closes. The block then raises `busy` for a self-timed programming period, after which it copies only the marked slots into the behavioural storage array, one slot per cycle. Strobes are ignored while `busy` is high and for a power-on delay after reset. A registered read port lets the surrounding logic observe the array contents.

Top module: `pwl_ctrl`

## Requirements
- R1: While reset is high and after it is released, `busy` is 0 until a load window times out.
- R2: A write strobe pulse taken while chip select is already low and output enable is high stores `wdata` at `addr` once programming ends.
- R3: A chip-select pulse taken while the write strobe is already low and output enable is high stores the byte in the same way.
- R4: A write needs the combined low condition to last at least FILT_CYC clock cycles; a shorter pulse is dropped and opens no window.
- R5: If output enable is low when the combined low condition ends, or for its whole length, no byte is taken.
- R6: Address bits [ADDR_W-1:6] of the first byte in a window fix the page; later bytes of that window use only their bits [5:0], so they land in the first byte's page.
- R7: Within one window, bytes may arrive in any order and the last value written to a slot wins; slots of the page that were not loaded keep their earlier array contents.
- R8: With two synchroniser stages, `busy` rises WIN_CYC+3 cycles after the input release of the last byte. A next write whose falling strobe comes WIN_CYC cycles after that release keeps the window open; one that comes WIN_CYC+1 cycles after it is too late.
- R9: `busy` stays high for exactly PROG_CYC + 64 + 1 cycles: the programming period, one commit cycle per slot, and one closing cycle.
- R10: A write whose strobe pulse falls within the busy period is ignored, and the array slot it targets is unchanged.
- R11: Writes are ignored during the first POR_CYC cycles after reset.
- R12: `rd_data` shows the array byte at `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | ADDR_W | Byte address; upper bits page, low 6 bits slot |
| wdata | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Registered array read data |
| busy | output | 1 | High during programming and commit |

## Verification
The bench concentrates on the window edge. It places a second byte exactly WIN_CYC cycles after a release, and then one cycle later. A design with an off-by-one timer would either split the first pair into two programming periods or accept the late byte during `busy`. Filter pulses of FILT_CYC-1 and FILT_CYC cycles target a wrong comparison. Moving the page bits between bytes of one window, and rewriting a slot, would expose a design that reprograms the whole page, takes the page from each byte, or keeps the first value instead of the last. Strobes issued during the power-on delay and during an output-enable abort must leave `busy` low and the array unchanged.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG,
    ST_COMMIT,
    ST_DONE
  } pwl_state_e;
endpackage

// File: rtl/pwl_strobe_qual.sv
module pwl_strobe_qual #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              blocked,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              strobe_low
);
  localparam int BW = 3 + ADDR_W + DATA_W;
  localparam int FW = $clog2(FILT_CYC + 1);

  logic [BW-1:0]     pipe [SYNC_STAGES];
  logic [BW-1:0]     tail;
  logic              ce_s, oe_s, we_s;
  logic [ADDR_W-1:0] a_s;
  logic [DATA_W-1:0] d_s;
  logic              wr_low, prev_low;
  logic [FW-1:0]     fcnt;

  // strobes, address and data share one delay chain so they stay aligned
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= {ce_n, oe_n, we_n, addr, wdata};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign tail = pipe[SYNC_STAGES-1];
  assign ce_s = tail[BW-1];
  assign oe_s = tail[BW-2];
  assign we_s = tail[BW-3];
  assign a_s  = tail[DATA_W +: ADDR_W];
  assign d_s  = tail[DATA_W-1:0];

  assign wr_low     = !ce_s && !we_s && oe_s;
  assign strobe_low = wr_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_low <= 1'b0;
      fcnt     <= '0;
    end else begin
      prev_low <= wr_low;
      if (wr_low && !blocked) begin
        if (fcnt != FW'(FILT_CYC)) fcnt <= fcnt + 1'b1;
      end else begin
        fcnt <= '0;
      end
    end
  end

  // address at the start of the low phase, data at its last cycle
  always_ff @(posedge clk) begin
    if (wr_low && !prev_low) ld_addr <= a_s;
    if (wr_low) ld_data <= d_s;
  end

  assign ld_valid = prev_low && !wr_low && oe_s && (fcnt == FW'(FILT_CYC)) && !blocked;
endmodule

// File: rtl/pwl_page_buf.sv
module pwl_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mark
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] slot [DEPTH];
  logic [DEPTH-1:0]  mark;

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) mark <= '0;
    else if (wr_en) mark[wr_off] <= 1'b1;
  end

  assign rd_data = slot[rd_off];
  assign rd_mark = mark[rd_off];
endmodule

// File: rtl/pwl_array.sv
module pwl_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/pwl_ctrl.sv
module pwl_ctrl
  import pwl_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3,
  parameter int WIN_CYC     = 30,
  parameter int PROG_CYC    = 50,
  parameter int POR_CYC     = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int TW     = $clog2(WIN_CYC + 1);
  localparam int PW     = $clog2(PROG_CYC + 1);
  localparam int RW     = $clog2(POR_CYC + 1);

  pwl_state_e        st;
  logic [PAGE_W-1:0] page_q;
  logic [TW-1:0]     tmr;
  logic [PW-1:0]     pcnt;
  logic [OFF_W-1:0]  idx;
  logic [RW-1:0]     por_cnt;
  logic              por_done, busy_q, blocked;

  logic              ld_valid, strobe_low;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;
  logic [DATA_W-1:0] buf_data;
  logic              buf_mark, commit_we;

  assign por_done = (por_cnt == RW'(POR_CYC));
  assign blocked  = busy_q || !por_done;

  pwl_strobe_qual #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)
  ) u_strobe (
    .clk(clk), .rst(rst),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .blocked(blocked),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .strobe_low(strobe_low)
  );

  pwl_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_page (
    .clk(clk), .rst(rst),
    .wr_en(ld_valid), .wr_off(ld_addr[OFF_W-1:0]), .wr_data(ld_data),
    .clr(st == ST_DONE), .rd_off(idx),
    .rd_data(buf_data), .rd_mark(buf_mark)
  );

  assign commit_we = (st == ST_COMMIT) && buf_mark;

  pwl_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(commit_we), .waddr({page_q, idx}), .wdata(buf_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      page_q  <= '0;
      tmr     <= '0;
      pcnt    <= '0;
      idx     <= '0;
      busy_q  <= 1'b0;
      por_cnt <= '0;
    end else begin
      if (!por_done) por_cnt <= por_cnt + 1'b1;
      case (st)
        ST_IDLE: begin
          if (ld_valid) begin
            page_q <= ld_addr[ADDR_W-1:OFF_W];
            tmr    <= '0;
            st     <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (ld_valid) begin
            tmr <= '0;
          end else if (!strobe_low) begin
            if (tmr == TW'(WIN_CYC - 1)) begin
              st     <= ST_PROG;
              pcnt   <= '0;
              busy_q <= 1'b1;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (pcnt == PW'(PROG_CYC - 1)) begin
            st  <= ST_COMMIT;
            idx <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_COMMIT: begin
          if (&idx) st <= ST_DONE;
          idx <= idx + 1'b1;
        end
        ST_DONE: begin
          st     <= ST_IDLE;
          busy_q <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = busy_q;

  // R10
  ld_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !ld_valid);

  // R11
  ld_before_por_chk: assert property (@(posedge clk) disable iff (rst)
    !por_done |-> !ld_valid);

  // R8
  busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> ($past(st == ST_LOAD) && $past(!strobe_low)));

  // R9
  busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(st == ST_DONE));

  // R7
  commit_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    commit_we |-> busy_q);
endmodule

// File: tb/pwl_ctrl_tb_top.sv
module pwl_ctrl_tb_top;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int FILT = 3;
  localparam int WIN = 30;
  localparam int PROG = 50;
  localparam int POR = 40;
  localparam int SLOTS = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic busy;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pwl_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .OFF_W(6), .SYNC_STAGES(2),
    .FILT_CYC(FILT), .WIN_CYC(WIN), .PROG_CYC(PROG), .POR_CYC(POR)
  ) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int pce[$], poe[$], pwe[$], pad[$], pdt[$];
  int m_prev, m_fc, m_pend, m_dh, m_phase, m_idle, m_pc, m_k, m_page, m_por;
  bit m_busy;
  int m_buf[SLOTS];
  bit m_mark[SLOTS];
  int mm[int];
  int exp_rd = -1;

  always @(posedge clk) begin
    if (rst) begin
      pce = '{1, 1}; poe = '{1, 1}; pwe = '{1, 1}; pad = '{0, 0}; pdt = '{0, 0};
      m_prev = 0; m_fc = 0; m_phase = 0; m_idle = 0; m_pc = 0; m_k = 0;
      m_por = 0; m_busy = 0;
      foreach (m_mark[i]) m_mark[i] = 0;
      exp_rd = -1;
    end else begin
      int c, o, w, a, d, wr, acc, blk, was;
      c = pce.pop_front(); o = poe.pop_front(); w = pwe.pop_front();
      a = pad.pop_front(); d = pdt.pop_front();
      pce.push_back(int'(ce_n)); poe.push_back(int'(oe_n)); pwe.push_back(int'(we_n));
      pad.push_back(int'(addr)); pdt.push_back(int'(wdata));
      exp_rd = mm.exists(int'(rd_addr)) ? mm[int'(rd_addr)] : -1;
      wr  = (c == 0 && w == 0 && o == 1);
      blk = m_busy || (m_por < POR);
      acc = m_prev && !wr && (o == 1) && (m_fc == FILT) && !blk;
      was = m_prev;
      if (m_por < POR) m_por++;
      m_fc = (wr && !blk) ? ((m_fc < FILT) ? m_fc + 1 : FILT) : 0;
      m_prev = wr;
      if (acc) begin
        m_buf[m_pend % SLOTS] = m_dh;
        m_mark[m_pend % SLOTS] = 1;
      end
      case (m_phase)
        0: if (acc) begin m_page = m_pend / SLOTS; m_idle = 0; m_phase = 1; end
        1: if (acc) m_idle = 0;
           else if (!wr) begin
             if (m_idle == WIN - 1) begin m_phase = 2; m_busy = 1; m_pc = 0; end
             else m_idle++;
           end
        2: if (m_pc == PROG - 1) begin m_phase = 3; m_k = 0; end else m_pc++;
        3: begin
             if (m_mark[m_k]) mm[m_page * SLOTS + m_k] = m_buf[m_k];
             if (m_k == SLOTS - 1) m_phase = 4;
             m_k++;
           end
        default: begin
          foreach (m_mark[i]) m_mark[i] = 0;
          m_phase = 0; m_busy = 0;
        end
      endcase
      if (wr && !was) m_pend = a;
      if (wr) m_dh = d;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "busy per cycle", {31'b0, busy}, {31'b0, m_busy});
      if (exp_rd >= 0) chk("R12", "rd_data per cycle", {24'b0, rd_data}, exp_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_we(input int a, input int d, input int low);
    @(negedge clk); addr = AW'(a); wdata = DW'(d); ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (low) @(negedge clk);
    we_n = 1'b1;
  endtask

  task automatic wr_ce(input int a, input int d, input int low);
    @(negedge clk); addr = AW'(a); wdata = DW'(d); we_n = 1'b0;
    @(negedge clk); ce_n = 1'b0;
    repeat (low) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_busy_len(output int len);
    len = 0;
    while (busy !== 1'b1) @(negedge clk);
    while (busy === 1'b1) begin len++; @(negedge clk); end
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk); chk(tag, "array byte", {24'b0, rd_data}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int len, n;
    idle(5);
    chk("R1", "busy in reset", {31'b0, busy}, 0);
    rst = 1'b0;

    // R11: strobe inside the power-on delay
    cur_req = "R11";
    wr_we(1 * 64 + 1, 8'h11, 4); ce_n = 1'b1;
    idle(80);
    chk("R11", "busy after early write", {31'b0, busy}, 0);

    // R2 with pulse exactly FILT long (R4 boundary), then R9 length
    cur_req = "R2";
    wr_we(3 * 64 + 5, 8'h5A, FILT);
    wr_we(3 * 64 + 7, 8'h10, 4); ce_n = 1'b1;
    wait_busy_len(len);
    chk("R9", "busy length", len, PROG + SLOTS + 1);
    rd_chk(3 * 64 + 5, 8'h5A, "R2");
    rd_chk(3 * 64 + 7, 8'h10, "R4");

    // R3: chip-select controlled write
    cur_req = "R3";
    wr_ce(3 * 64 + 6, 8'hC3, 4);
    wait_busy_len(len);
    rd_chk(3 * 64 + 6, 8'hC3, "R3");

    // R4: pulse one cycle too short
    cur_req = "R4";
    wr_we(3 * 64 + 7, 8'h77, FILT - 1); ce_n = 1'b1;
    idle(WIN + 10);
    chk("R4", "busy after short pulse", {31'b0, busy}, 0);
    rd_chk(3 * 64 + 7, 8'h10, "R4");

    // R5: output enable low all through, then dropping mid pulse
    cur_req = "R5";
    oe_n = 1'b0;
    wr_we(3 * 64 + 7, 8'h66, 4); ce_n = 1'b1;
    idle(3); oe_n = 1'b1;
    @(negedge clk); addr = AW'(3 * 64 + 7); wdata = 8'h67; ce_n = 1'b0; we_n = 1'b0;
    idle(4); oe_n = 1'b0;
    idle(2); we_n = 1'b1; ce_n = 1'b1;
    idle(3); oe_n = 1'b1;
    idle(WIN + 10);
    chk("R5", "busy after inhibited writes", {31'b0, busy}, 0);
    rd_chk(3 * 64 + 7, 8'h10, "R5");

    // prewrite slots for R6/R7
    cur_req = "R7";
    wr_we(5 * 64 + 20, 8'h99, 4); ce_n = 1'b1;
    wait_busy_len(len);
    wr_we(9 * 64 + 0, 8'h55, 4); ce_n = 1'b1;
    wait_busy_len(len);

    // R6/R7: page from first byte, any order, last value wins
    cur_req = "R6";
    wr_we(5 * 64 + 63, 8'h01, 4);
    wr_we(9 * 64 + 0, 8'h02, 4);
    wr_we(5 * 64 + 10, 8'h03, 4);
    wr_we(5 * 64 + 10, 8'h04, 4); ce_n = 1'b1;
    wait_busy_len(len);
    chk("R9", "busy length multi-byte", len, PROG + SLOTS + 1);
    rd_chk(5 * 64 + 63, 8'h01, "R7");
    rd_chk(5 * 64 + 0, 8'h02, "R6");
    rd_chk(9 * 64 + 0, 8'h55, "R6");
    rd_chk(5 * 64 + 10, 8'h04, "R7");
    rd_chk(5 * 64 + 20, 8'h99, "R7");

    // R8: gap of exactly WIN keeps the window, then timeout latency
    cur_req = "R8";
    wr_we(7 * 64 + 1, 8'h21, 4);
    idle(WIN - 2);
    wr_we(7 * 64 + 2, 8'h22, 4); ce_n = 1'b1;
    n = 0;
    while (busy !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk("R8", "release to busy cycles", n, WIN + 3);
    while (busy === 1'b1) @(negedge clk);
    rd_chk(7 * 64 + 1, 8'h21, "R8");
    rd_chk(7 * 64 + 2, 8'h22, "R8");

    // R10: gap of WIN+1 is too late; byte lands in busy and is lost
    cur_req = "R10";
    wr_we(7 * 64 + 3, 8'h33, 4);
    idle(WIN - 1);
    wr_we(3 * 64 + 5, 8'hEE, 4); ce_n = 1'b1;
    wait_busy_len(len);
    idle(WIN + 10);
    chk("R10", "busy after lost byte", {31'b0, busy}, 0);
    rd_chk(7 * 64 + 3, 8'h33, "R10");
    rd_chk(3 * 64 + 5, 8'h5A, "R10");

    // R12: back-to-back reads of different addresses
    cur_req = "R12";
    rd_chk(7 * 64 + 1, 8'h21, "R12");
    rd_chk(3 * 64 + 6, 8'hC3, "R12");

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule